// File: doc/BRIEF.md
# Boot Remap and Alias Address Decoder

This block is the address decoder of a small microcontroller bus. Every address-phase address is turned, in the same cycle, into a one-hot select for one of seven targets, along with the offset of that address inside the chosen target. The targets are the on-chip RAM, two external SSRAM banks, NOR flash, the peripheral bridge window, an expansion port that forwards traffic off-chip, and an internal error responder for reserved holes.

Two software bits change the low part of the map while the system runs. The first bit, `remap`, places the second SSRAM bank over the bottom 4 MB so that code can run from RAM. The second bit, `alias`, opens a second window onto flash. Both bits live in a small register that only the power-on reset clears, so a system reset or debug reset does not change the boot map.

A data-phase tracker samples the select at each accepted address phase and holds it for the response mux. The same tracker drives a two-cycle ERROR response for transfers that reach a reserved hole. Its states are `DP_IDLE` (no transfer in data phase), `DP_XFER` (a transfer to a real target), `DP_ERR_WAIT` (first error cycle, bus stalled) and `DP_ERR_DONE` (second error cycle). Its transitions are named *accept-ok* (to `DP_XFER`), *accept-bad* (to `DP_ERR_WAIT`), *finish-error* (`DP_ERR_WAIT` to `DP_ERR_DONE`), *go-idle* (to `DP_IDLE` when the bus is ready and no transfer is requested) and *stall* (the state is held while the bus is not ready).

Top module: `boot_map_decoder`

## Requirements
- R1: With remap=0, addresses 0x0000_0000 to 0x03FF_FFFF select flash, with offset = address[25:0].
- R2: With remap=1, addresses 0x0000_0000 to 0x003F_FFFF select SSRAM1 with offset = address[21:0]. Addresses 0x0040_0000 to 0x03FF_FFFF still select flash, with offset = address[25:0].
- R3: Addresses 0x1000_0000 to 0x103F_FFFF select SSRAM1 with offset = address[21:0], whatever the value of remap.
- R4: With alias=1, addresses 0x1800_0000 to 0x1BFF_FFFF select flash with offset = address[25:0]. With alias=0, the same window selects the error responder.
- R5: The fixed windows decode as follows:
  - RAM at 0x1EFF_0000 to 0x1EFF_FFFF, offset [15:0].
  - SSRAM0 at 0x2000_0000 to 0x203F_FFFF, offset [21:0].
  - Bridge at 0xDFFF_0000 to 0xDFFF_FFFF, offset [15:0].
- R6: The select output is always one-hot. Its bits are: 0 RAM, 1 SSRAM0, 2 SSRAM1, 3 flash, 4 bridge, 5 expansion, 6 error responder.
  - Expansion takes 0x3000_0000 to 0xDFFE_FFFF and 0xE010_0000 to 0xFFFF_FFFF.
  - Every other unlisted address below 0x3000_0000, and all of 0xE000_0000 to 0xE00F_FFFF, select the error responder.
  - The offset for expansion and the error responder is address[25:0].
- R7: The control register holds remap in bit 0 and alias in bit 1. It powers up as 0b10 (remap=0, alias=1). A write strobe loads both bits at the clock edge. The 32-bit read value has bits 31:2 at zero.
- R8: The control register is cleared only by the power-on reset. Asserting the system reset leaves it unchanged.
- R9: The select and offset outputs are combinational from the address and the register, valid in the same cycle and with no wait state.
- R10: A register write changes the decode only for address phases sampled after the write edge. The data-phase select, captured at the address-phase edge, keeps the target chosen with the old setting.
- R11: A transfer (htrans = 2'b10 or 2'b11) accepted to the error responder gets two response cycles:
  - first cycle: hresp=1 with hready=0;
  - second cycle: hresp=1 with hready=1.
  - Idle transfers get a zero-wait OKAY response, and the data-phase select then reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hresetn | input | 1 | System reset, active low, asynchronous |
| haddr_i | input | 32 | Address-phase address |
| htrans_i | input | 2 | Transfer type |
| bus_hready_i | input | 1 | Bus ready, marks accepted address phases |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 2 | Write data: bit 0 remap, bit 1 alias |
| cfg_rdata_o | output | 32 | Control register read value |
| sel_o | output | 7 | One-hot address-phase select |
| offs_o | output | 26 | Offset inside the selected target |
| dsel_o | output | 7 | Select held for the data phase |
| dflt_hready_o | output | 1 | Ready from the error responder |
| dflt_hresp_o | output | 1 | Response from the error responder (1 = ERROR) |

## Verification
The select and offset are due in the same cycle that the address is driven. Their checks sample 2 ns after the falling edge on which the address was driven, before the next rising edge. The register read value and the changed decode are due one rising edge after the write strobe, and the bench only checks decodes driven after that edge. The data-phase select and the first ERROR cycle are due one rising edge after the address phase, and the second ERROR cycle one edge later. Each of these is sampled at the falling edge that follows the edge where it is due.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int CFG_W    = 2;
    localparam int OFFS_W   = 26;
    localparam int SSRAM_AW = 22;
    localparam int SMALL_AW = 16;
    localparam int NUM_TGT  = 7;

    typedef enum logic [2:0] {
        RG_RAM    = 3'd0,
        RG_SSRAM0 = 3'd1,
        RG_SSRAM1 = 3'd2,
        RG_FLASH  = 3'd3,
        RG_APB    = 3'd4,
        RG_EXP    = 3'd5,
        RG_DFLT   = 3'd6
    } region_e;

    typedef enum logic [1:0] {
        DP_IDLE,
        DP_XFER,
        DP_ERR_WAIT,
        DP_ERR_DONE
    } dphase_e;
endpackage

// File: rtl/map_cfg_reg.sv
module map_cfg_reg
    import boot_map_pkg::*;
(
    input  logic             hclk,
    input  logic             por_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic             remap_o,
    output logic             alias_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [CFG_W-1:0] POR_VALUE = 2'b10;

    logic [CFG_W-1:0] cfg_q;

    // Only the power-on reset reaches this register.
    always_ff @(posedge hclk or negedge por_n) begin
        if (!por_n)    cfg_q <= POR_VALUE;
        else if (we_i) cfg_q <= wdata_i;
    end

    assign remap_o = cfg_q[0];
    assign alias_o = cfg_q[1];
    assign rdata_o = {{(DATA_W-CFG_W){1'b0}}, cfg_q};

    // R8: without a write strobe, the setting survives every edge.
    p_cfg_hold_r8: assert property (@(posedge hclk) disable iff (!por_n)
        !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/map_region_decode.sv
module map_region_decode
    import boot_map_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               remap_i,
    input  logic               alias_i,
    output logic [NUM_TGT-1:0] sel_o,
    output logic [OFFS_W-1:0]  offs_o
);
    region_e region;

    always_comb begin
        region = RG_EXP;
        if (addr_i[31:26] == 6'h00) begin
            // bottom 64 MB: flash, with SSRAM1 laid over the first 4 MB on remap
            if (remap_i && addr_i[25:22] == 4'h0) region = RG_SSRAM1;
            else                                  region = RG_FLASH;
        end else if (addr_i[31:22] == 10'h040) begin
            region = RG_SSRAM1;
        end else if (addr_i[31:26] == 6'h06) begin
            region = alias_i ? RG_FLASH : RG_DFLT;
        end else if (addr_i[31:16] == 16'h1EFF) begin
            region = RG_RAM;
        end else if (addr_i[31:22] == 10'h080) begin
            region = RG_SSRAM0;
        end else if (addr_i[31:16] == 16'hDFFF) begin
            region = RG_APB;
        end else if (addr_i[31:28] < 4'h3) begin
            region = RG_DFLT;
        end else if (addr_i[31:20] == 12'hE00) begin
            region = RG_DFLT;
        end
    end

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
        assign sel_o[g] = (region == region_e'(g));
    end

    always_comb begin
        unique case (region)
            RG_SSRAM0, RG_SSRAM1:
                offs_o = {{(OFFS_W-SSRAM_AW){1'b0}}, addr_i[SSRAM_AW-1:0]};
            RG_RAM, RG_APB:
                offs_o = {{(OFFS_W-SMALL_AW){1'b0}}, addr_i[SMALL_AW-1:0]};
            default:
                offs_o = addr_i[OFFS_W-1:0];
        endcase
    end
endmodule

// File: rtl/map_dphase_ctrl.sv
module map_dphase_ctrl
    import boot_map_pkg::*;
(
    input  logic               hclk,
    input  logic               hresetn,
    input  logic [1:0]         htrans_i,
    input  logic               hready_i,
    input  logic [NUM_TGT-1:0] sel_i,
    output logic [NUM_TGT-1:0] dsel_o,
    output logic               hready_o,
    output logic               hresp_o
);
    dphase_e state, state_nxt;
    logic [NUM_TGT-1:0] dsel_q;
    logic xfer;

    assign xfer = (htrans_i == 2'b10) || (htrans_i == 2'b11);

    always_comb begin
        state_nxt = state;
        unique case (state)
            DP_ERR_WAIT: state_nxt = DP_ERR_DONE;
            DP_IDLE, DP_XFER, DP_ERR_DONE: begin
                if (hready_i) begin
                    if (!xfer)                      state_nxt = DP_IDLE;
                    else if (sel_i[int'(RG_DFLT)])  state_nxt = DP_ERR_WAIT;
                    else                            state_nxt = DP_XFER;
                end
            end
        endcase
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            state  <= DP_IDLE;
            dsel_q <= '0;
        end else begin
            state <= state_nxt;
            if (state != DP_ERR_WAIT && hready_i)
                dsel_q <= xfer ? sel_i : '0;
        end
    end

    always_comb begin
        hready_o = 1'b1;
        hresp_o  = 1'b0;
        unique case (state)
            DP_ERR_WAIT: begin hready_o = 1'b0; hresp_o = 1'b1; end
            DP_ERR_DONE: begin hready_o = 1'b1; hresp_o = 1'b1; end
            DP_IDLE, DP_XFER: begin hready_o = 1'b1; hresp_o = 1'b0; end
        endcase
    end

    assign dsel_o = dsel_q;

    // R11: a stalled ERROR cycle is always followed by the completing one.
    p_err_second_r11: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp_o && !hready_o) |=> (hresp_o && hready_o));
    // R10: the data-phase target does not move while the bus is stalled.
    p_dsel_hold_r10: assert property (@(posedge hclk) disable iff (!hresetn)
        !hready_i |=> $stable(dsel_q));
    // R6: at most one target owns the data phase.
    p_dsel_onehot0_r6: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot0(dsel_q));
endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
    import boot_map_pkg::*;
(
    input  logic               hclk,
    input  logic               por_n,
    input  logic               hresetn,
    input  logic [ADDR_W-1:0]  haddr_i,
    input  logic [1:0]         htrans_i,
    input  logic               bus_hready_i,
    input  logic               cfg_we_i,
    input  logic [CFG_W-1:0]   cfg_wdata_i,
    output logic [DATA_W-1:0]  cfg_rdata_o,
    output logic [NUM_TGT-1:0] sel_o,
    output logic [OFFS_W-1:0]  offs_o,
    output logic [NUM_TGT-1:0] dsel_o,
    output logic               dflt_hready_o,
    output logic               dflt_hresp_o
);
    logic remap, alias_en;

    map_cfg_reg u_cfg (
        .hclk    (hclk),
        .por_n   (por_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .remap_o (remap),
        .alias_o (alias_en),
        .rdata_o (cfg_rdata_o)
    );

    map_region_decode u_dec (
        .addr_i  (haddr_i),
        .remap_i (remap),
        .alias_i (alias_en),
        .sel_o   (sel_o),
        .offs_o  (offs_o)
    );

    map_dphase_ctrl u_dp (
        .hclk     (hclk),
        .hresetn  (hresetn),
        .htrans_i (htrans_i),
        .hready_i (bus_hready_i),
        .sel_i    (sel_o),
        .dsel_o   (dsel_o),
        .hready_o (dflt_hready_o),
        .hresp_o  (dflt_hresp_o)
    );

    // R6: exactly one target for every address.
    p_sel_onehot_r6: assert property (@(posedge hclk) disable iff (!por_n)
        $onehot(sel_o));
    // R2: a set remap bit hands the bottom 4 MB to SSRAM1.
    p_remap_low_r2: assert property (@(posedge hclk) disable iff (!por_n)
        (cfg_rdata_o[0] && haddr_i[31:22] == 10'h000) |-> sel_o[int'(RG_SSRAM1)]);
    // R4: a cleared alias bit turns the second flash window into a hole.
    p_alias_off_r4: assert property (@(posedge hclk) disable iff (!por_n)
        (!cfg_rdata_o[1] && haddr_i[31:26] == 6'h06) |-> sel_o[int'(RG_DFLT)]);
endmodule

// File: tb/boot_map_decoder_tb_top.sv
module boot_map_decoder_tb_top;
    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        por_n, hresetn;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        cfg_we;
    logic [1:0]  cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [6:0]  sel, dsel;
    logic [25:0] offs;
    logic        d_hready, d_hresp;

    boot_map_decoder dut_i (
        .hclk          (clk),
        .por_n         (por_n),
        .hresetn       (hresetn),
        .haddr_i       (haddr),
        .htrans_i      (htrans),
        .bus_hready_i  (d_hready),
        .cfg_we_i      (cfg_we),
        .cfg_wdata_i   (cfg_wdata),
        .cfg_rdata_o   (cfg_rdata),
        .sel_o         (sel),
        .offs_o        (offs),
        .dsel_o        (dsel),
        .dflt_hready_o (d_hready),
        .dflt_hresp_o  (d_hresp)
    );

    int checks = 0;
    int fails  = 0;
    bit m_remap = 1'b0;
    bit m_alias = 1'b1;

    logic [31:0] q_addr[$];
    logic [6:0]  q_sel[$];
    logic [25:0] q_off[$];
    string       q_tag[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected map, written from the requirements.
    function automatic void model(input logic [31:0] a, input bit rm, input bit al,
                                  output logic [6:0] s, output logic [25:0] o);
        o = a[25:0];
        s = 7'b100_0000;
        if (a <= 32'h03FF_FFFF) begin
            if (rm && a <= 32'h003F_FFFF) begin s = 7'b000_0100; o = {4'b0, a[21:0]}; end
            else s = 7'b000_1000;
        end else if (a >= 32'h1000_0000 && a <= 32'h103F_FFFF) begin
            s = 7'b000_0100; o = {4'b0, a[21:0]};
        end else if (a >= 32'h1800_0000 && a <= 32'h1BFF_FFFF) begin
            s = al ? 7'b000_1000 : 7'b100_0000;
        end else if (a >= 32'h1EFF_0000 && a <= 32'h1EFF_FFFF) begin
            s = 7'b000_0001; o = {10'b0, a[15:0]};
        end else if (a >= 32'h2000_0000 && a <= 32'h203F_FFFF) begin
            s = 7'b000_0010; o = {4'b0, a[21:0]};
        end else if (a >= 32'hDFFF_0000 && a <= 32'hDFFF_FFFF) begin
            s = 7'b001_0000; o = {10'b0, a[15:0]};
        end else if ((a >= 32'h3000_0000 && a <= 32'hDFFE_FFFF) || a >= 32'hE010_0000) begin
            s = 7'b010_0000;
        end
    endfunction

    // Driver: present an address and queue what the decode must show.
    task automatic drive_addr(input logic [31:0] a, input string tag);
        logic [6:0]  s;
        logic [25:0] o;
        @(negedge clk);
        haddr = a;
        model(a, m_remap, m_alias, s, o);
        q_addr.push_back(a); q_sel.push_back(s); q_off.push_back(o); q_tag.push_back(tag);
    endtask

    // Monitor: the decode is combinational (R9), so it is compared in the same cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_sel.size() > 0) begin
                logic [31:0] a;
                logic [6:0]  s;
                logic [25:0] o;
                string       t;
                a = q_addr.pop_front(); s = q_sel.pop_front();
                o = q_off.pop_front();  t = q_tag.pop_front();
                chk(sel == s, {t, " select"}, {25'b0, sel}, {25'b0, s});
                chk(offs == o, {t, " offset"}, {6'b0, offs}, {6'b0, o});
            end
        end
    end

    task automatic write_cfg(input logic [1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        m_remap = v[0]; m_alias = v[1];
    endtask

    bit done = 1'b0;
    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; hresetn = 1'b0; haddr = '0; htrans = 2'b00;
        cfg_we = 1'b0; cfg_wdata = 2'b00;
        repeat (3) @(negedge clk);
        por_n = 1'b1; hresetn = 1'b1;
        #2;
        chk(cfg_rdata == 32'h2, "R7 power-on value", cfg_rdata, 32'h2);
        chk(dsel == 7'b0, "R11 reset data select", {25'b0, dsel}, 32'h0);
        chk(d_hready && !d_hresp, "R11 reset response", {30'b0, d_hready, d_hresp}, 32'h2);

        // remap=0, alias=1
        drive_addr(32'h0000_0000, "R9");
        drive_addr(32'h03FF_FFFC, "R1");
        drive_addr(32'h0012_3456, "R1");
        drive_addr(32'h1000_1234, "R3");
        drive_addr(32'h1800_0040, "R4");
        drive_addr(32'h1BFF_FFFF, "R4");
        drive_addr(32'h1EFF_ABCD, "R5");
        drive_addr(32'h2012_3456, "R5");
        drive_addr(32'hDFFF_0028, "R5");
        drive_addr(32'h3000_0000, "R6");
        drive_addr(32'hDFFE_FFFF, "R6");
        drive_addr(32'hE000_1000, "R6");
        drive_addr(32'hE010_0000, "R6");
        drive_addr(32'hFFFF_FFFC, "R6");
        drive_addr(32'h0400_0000, "R6");
        drive_addr(32'h1040_0000, "R6");
        drive_addr(32'h1F00_0000, "R6");
        drive_addr(32'h2040_0000, "R6");

        // remap=1, alias=0
        write_cfg(2'b01);
        #2;
        chk(cfg_rdata == 32'h1, "R7 read after write", cfg_rdata, 32'h1);
        drive_addr(32'h0000_0010, "R2");
        drive_addr(32'h003F_FFFF, "R2");
        drive_addr(32'h0040_0000, "R2");
        drive_addr(32'h03FF_0000, "R2");
        drive_addr(32'h1000_0010, "R3");
        drive_addr(32'h1800_0000, "R4");
        drive_addr(32'h1BFF_FFFF, "R4");

        // R8: system reset leaves the register alone, power-on reset restores it
        @(negedge clk); hresetn = 1'b0;
        repeat (2) @(negedge clk);
        #2;
        chk(cfg_rdata == 32'h1, "R8 system reset keeps setting", cfg_rdata, 32'h1);
        hresetn = 1'b1;
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        m_remap = 1'b0; m_alias = 1'b1;
        #2;
        chk(cfg_rdata == 32'h2, "R8 power-on reset restores", cfg_rdata, 32'h2);

        // R10: a write in the same cycle as an address phase leaves that transfer on the old map
        @(negedge clk);
        haddr = 32'h0000_0100; htrans = 2'b10;
        cfg_we = 1'b1; cfg_wdata = 2'b11;
        @(negedge clk);
        cfg_we = 1'b0; htrans = 2'b00;
        m_remap = 1'b1; m_alias = 1'b1;
        #2;
        chk(dsel == 7'b000_1000, "R10 data phase keeps flash", {25'b0, dsel}, 32'h08);
        chk(sel == 7'b000_0100, "R10 next phase sees SSRAM1", {25'b0, sel}, 32'h04);
        @(negedge clk); #2;
        chk(dsel == 7'b0, "R11 idle clears data select", {25'b0, dsel}, 32'h0);

        // R11: zero-wait OKAY to a real target
        @(negedge clk);
        haddr = 32'h2000_0000; htrans = 2'b11;
        @(negedge clk);
        htrans = 2'b00;
        #2;
        chk(dsel == 7'b000_0010 && d_hready && !d_hresp, "R11 okay transfer",
            {23'b0, dsel, d_hready, d_hresp}, {23'b0, 7'b000_0010, 2'b10});

        // R11: two-cycle ERROR for a reserved hole
        @(negedge clk);
        haddr = 32'h0400_0000; htrans = 2'b10;
        @(negedge clk);
        htrans = 2'b00;
        #2;
        chk(!d_hready && d_hresp, "R11 error first cycle", {30'b0, d_hready, d_hresp}, 32'h1);
        chk(dsel == 7'b100_0000, "R11 error data select", {25'b0, dsel}, 32'h40);
        @(negedge clk); #2;
        chk(d_hready && d_hresp, "R11 error second cycle", {30'b0, d_hready, d_hresp}, 32'h3);
        @(negedge clk); #2;
        chk(d_hready && !d_hresp, "R11 back to okay", {30'b0, d_hready, d_hresp}, 32'h2);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule